// File: doc/BRIEF.md
# Ping-Pong Peripheral DMA Channel

This block is one DMA channel that moves words between memory and a single peripheral, in either direction. It holds two buffer slots, each a start address and a byte count. While one slot is being drained, software refills the other, so the data stream continues without a gap as long as the refill arrives in time. A four-state channel machine (idle, stall, on, next) tracks how many slots are loaded. Software is told through flags and a single interrupt line when a slot becomes free for refill and when the channel has run dry.

Software programs the channel through a small word-addressed register window. The memory side is a simple master that requests one word per cycle and completes the word when the memory raises ready. The peripheral side asks for words with a request level and receives an acknowledge pulse for each word moved. Each moved word advances the slot address by the word size in bytes and lowers its count by the same amount. When the count is smaller than a word, the last transfer takes the remainder.

Top module: `pingpong_dma_chan`

## Requirements
- R1: After reset, status reads 0 (idle), control reads 0, `irq` is low and `mem_req` is low.
- R2: Writing a nonzero count to a slot (slot 0 count at 0x20, slot 1 count at 0x30) marks the slot loaded, and writing zero marks it empty. With the channel enabled (control bit 4), status bits [5:4] read 2 (on) while one slot is loaded and 3 (next) while both are loaded.
- R3: `mem_req` is high only while the channel is enabled, on or next, and `per_req` is high. `mem_addr` starts at the slot base (slot 0 at 0x24, slot 1 at 0x34) and advances by 4 for each word completed. The base register reads back the current address.
- R4: Control bit 2 picks the direction. When it is 0, memory is read (`mem_we` low) and `per_wdata` carries `mem_rdata`. When it is 1, memory is written (`mem_we` high) and `mem_wdata` carries `per_rdata`. `per_ack` pulses for each completed word.
- R5: When a slot's count is used up, the slot is freed and the free-slot flag (interrupt register 0x04, bit 1) is set. If the other slot is loaded, the channel continues from it with no idle cycle.
- R6: When no slot is left, status reads 1 (stall), interrupt bit 0 reads 1 and `mem_req` stays low. Loading a slot returns the channel to on.
- R7: Writing either count register clears the free-slot flag.
- R8: A completed word with `mem_err` high sets interrupt bit 3, unless control bit 6 is set. Writing 1 to interrupt bit 3 clears it.
- R9: `irq` is high exactly when a pending stall, free-slot or error flag has its enable set (control bits 0, 1 and 3 respectively).
- R10: Clearing control bit 4 drops `mem_req` at once, and status reads 0 one cycle later. The shutdown order (clear the interrupt enables, wait until status is below 2, disable, wait until status is not 1) ends in idle.
- R11: The port register at 0x08 keeps only its low 4 bits, and these drive `per_sel`.
- R12: Counts are 16 bits, so the maximum is 0xFFFF and higher write bits are dropped. A count that is not a multiple of 4 ends with a partial last word and then reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ready | input | 1 | Memory completes the requested word |
| mem_rdata | input | DATA_W | Memory read data |
| mem_err | input | 1 | Error response with the completed word |
| per_req | input | 1 | Peripheral ready for a word |
| per_ack | output | 1 | A word was moved this cycle |
| per_sel | output | 4 | Selected peripheral |
| per_wdata | output | DATA_W | Data to the peripheral |
| per_rdata | input | DATA_W | Data from the peripheral |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the handover from one slot to the other with no idle cycle between them. It requires both slots to be loaded before the peripheral starts asking, and the last word of the first slot and the first word of the second must fall on consecutive edges. The stimulus loads both slots with the channel enabled and the peripheral request held low. It then raises the request and checks the address on every cycle across the switch, until the channel stalls. A second hard case is a disable while words are still flowing. It is reached by cutting the enable after two words of a long buffer.

// File: rtl/pp_dma_pkg.sv
// Shared types and register offsets for the ping-pong DMA channel.
package pp_dma_pkg;
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_STALL = 2'd1,
        CH_ON    = 2'd2,
        CH_NEXT  = 2'd3
    } ch_state_e;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_INT    = 8'h04;
    localparam logic [7:0] OFS_PORT   = 8'h08;
    localparam logic [7:0] OFS_STATUS = 8'h0C;
    localparam logic [7:0] OFS_CNT0   = 8'h20;
    localparam logic [7:0] OFS_BASE0  = 8'h24;
    localparam logic [7:0] OFS_CNT1   = 8'h30;
    localparam logic [7:0] OFS_BASE1  = 8'h34;
endpackage

// File: rtl/pp_dma_slots.sv
// Two buffer slots, each an address, a remaining byte count and a loaded bit.
// Assumes ADDR_W and CNT_W are at most 32 bits. The engine advances only the
// current slot, and only while that slot is loaded.
module pp_dma_slots #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int STEP_B = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  cnt_we,
    input  logic [1:0]                  base_we,
    input  logic [31:0]                 wdata,
    input  logic                        adv,
    input  logic                        cur,
    output logic [1:0]                  valid,
    output logic [1:0]                  valid_nxt,
    output logic [1:0][CNT_W-1:0]       cnt,
    output logic [1:0][ADDR_W-1:0]      addr,
    output logic                        last
);
    localparam logic [CNT_W-1:0]  STEP_C = CNT_W'(STEP_B);
    localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP_B);

    logic [CNT_W-1:0] wr_cnt;
    assign wr_cnt = wdata[CNT_W-1:0];
    assign last   = (cnt[cur] <= STEP_C);

    for (genvar s = 0; s < 2; s++) begin : g_slot
        logic hit;
        assign hit = adv && (cur == 1'(s));

        // Loaded bit as it will be after this edge, for the channel machine.
        always_comb begin
            if (cnt_we[s])        valid_nxt[s] = |wr_cnt;
            else if (hit && last) valid_nxt[s] = 1'b0;
            else                  valid_nxt[s] = valid[s];
        end

        // Slot address: bus load, else advance by one word per completed beat.
        always_ff @(posedge clk) begin
            if (!rst_n)          addr[s] <= '0;
            else if (base_we[s]) addr[s] <= wdata[ADDR_W-1:0];
            else if (hit)        addr[s] <= addr[s] + STEP_A;
        end

        // Remaining count and loaded bit: bus load, else drain per beat.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt[s]   <= '0;
                valid[s] <= 1'b0;
            end else if (cnt_we[s]) begin
                cnt[s]   <= wr_cnt;
                valid[s] <= |wr_cnt;
            end else if (hit) begin
                cnt[s]   <= last ? '0 : cnt[s] - STEP_C;
                valid[s] <= !last;
            end
        end
    end
endmodule

// File: rtl/pp_dma_fsm.sv
// Four-state channel machine and current-slot pointer. It takes the slot
// loaded bits as they will be after this edge, so a load takes effect at
// once. Disabling forces idle and leaves the pointer where it is.
module pp_dma_fsm
    import pp_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       adv,
    input  logic       last,
    input  logic [1:0] vnext,
    output ch_state_e  state,
    output logic       cur
);
    logic oth;
    assign oth = ~cur;

    // State and pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CH_IDLE;
            cur   <= 1'b0;
        end else if (!enable) begin
            state <= CH_IDLE;
        end else begin
            case (state)
                CH_IDLE, CH_STALL: begin
                    if (vnext[cur]) begin
                        state <= vnext[oth] ? CH_NEXT : CH_ON;
                    end else if (vnext[oth]) begin
                        cur   <= oth;
                        state <= CH_ON;
                    end
                end
                default: begin
                    if ((adv && last) || !vnext[cur]) begin
                        if (vnext[oth]) begin
                            cur   <= oth;
                            state <= vnext[cur] ? CH_NEXT : CH_ON;
                        end else begin
                            state <= CH_STALL;
                        end
                    end else begin
                        state <= vnext[oth] ? CH_NEXT : CH_ON;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/pp_dma_regs.sv
// Register window: control, interrupt flags, port select, status and the
// slot readback. Writes take effect at the next edge and reads are
// combinational. The stall flag follows the channel state. The free-slot
// and error flags are sticky.
module pp_dma_regs
    import pp_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [7:0]             addr,
    input  logic [31:0]            wdata,
    output logic [31:0]            rdata,
    input  ch_state_e              state,
    input  logic [1:0][CNT_W-1:0]  cnt,
    input  logic [1:0][ADDR_W-1:0] base,
    input  logic                   done_evt,
    input  logic                   err_evt,
    output logic [1:0]             cnt_we,
    output logic [1:0]             base_we,
    output logic                   en,
    output logic                   to_mem,
    output logic                   ign_err,
    output logic [3:0]             port,
    output logic                   irq
);
    logic ie_stall, ie_free, ie_err;
    logic free_q, err_q, stall_p;

    assign cnt_we  = {we && addr == OFS_CNT1,  we && addr == OFS_CNT0};
    assign base_we = {we && addr == OFS_BASE1, we && addr == OFS_BASE0};
    assign stall_p = (state == CH_STALL);
    assign irq     = (ie_stall && stall_p) || (ie_free && free_q) || (ie_err && err_q);

    // Control and port registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {ie_stall, ie_free, to_mem, ie_err, en, ign_err} <= '0;
            port <= '0;
        end else if (we && addr == OFS_CTRL) begin
            ie_stall <= wdata[0];
            ie_free  <= wdata[1];
            to_mem   <= wdata[2];
            ie_err   <= wdata[3];
            en       <= wdata[4];
            ign_err  <= wdata[6];
        end else if (we && addr == OFS_PORT) begin
            port <= wdata[3:0];
        end
    end

    // Sticky flags: a new event wins over its clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (done_evt)     free_q <= 1'b1;
            else if (|cnt_we) free_q <= 1'b0;
            if (err_evt)                                    err_q <= 1'b1;
            else if (we && addr == OFS_INT && wdata[3])     err_q <= 1'b0;
        end
    end

    // Read mux.
    always_comb begin
        case (addr)
            OFS_CTRL:   rdata = {25'd0, ign_err, 1'b0, en, ie_err, to_mem, ie_free, ie_stall};
            OFS_INT:    rdata = {28'd0, err_q, 1'b0, free_q, stall_p};
            OFS_PORT:   rdata = {28'd0, port};
            OFS_STATUS: rdata = {26'd0, state, 4'd0};
            OFS_CNT0:   rdata = 32'(cnt[0]);
            OFS_CNT1:   rdata = 32'(cnt[1]);
            OFS_BASE0:  rdata = 32'(base[0]);
            OFS_BASE1:  rdata = 32'(base[1]);
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/pingpong_dma_chan.sv
// Top: joins the registers, slots and channel machine to the memory and
// peripheral sides. A word moves in each cycle where the request is high and
// memory is ready. Assumes ADDR_W and CNT_W are at most 32 and DATA_W is a
// whole number of bytes.
module pingpong_dma_chan
    import pp_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_err,
    input  logic              per_req,
    output logic              per_ack,
    output logic [3:0]        per_sel,
    output logic [DATA_W-1:0] per_wdata,
    input  logic [DATA_W-1:0] per_rdata,
    output logic              irq
);
    localparam int STEP_B = DATA_W / 8;

    ch_state_e              state;
    logic                   cur, last, beat, en, to_mem, ign_err;
    logic [1:0]             cnt_we, base_we, slot_valid, vnext;
    logic [1:0][CNT_W-1:0]  cnt;
    logic [1:0][ADDR_W-1:0] base;

    assign mem_req   = en && (state == CH_ON || state == CH_NEXT) && per_req;
    assign beat      = mem_req && mem_ready;
    assign mem_addr  = base[cur];
    assign mem_we    = to_mem;
    assign mem_wdata = per_rdata;
    assign per_wdata = mem_rdata;
    assign per_ack   = beat;

    pp_dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .state(state), .cnt(cnt),
        .base(base), .done_evt(beat && last), .err_evt(beat && mem_err && !ign_err),
        .cnt_we(cnt_we), .base_we(base_we), .en(en), .to_mem(to_mem),
        .ign_err(ign_err), .port(per_sel), .irq(irq)
    );

    pp_dma_slots #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STEP_B(STEP_B)) u_slots (
        .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .base_we(base_we),
        .wdata(reg_wdata), .adv(beat), .cur(cur), .valid(slot_valid),
        .valid_nxt(vnext), .cnt(cnt), .addr(base), .last(last)
    );

    pp_dma_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(en), .adv(beat), .last(last),
        .vnext(vnext), .state(state), .cur(cur)
    );
endmodule

// File: rtl/pp_dma_chan_chk.sv
// Property checker for the ping-pong DMA channel, bound to the top module.
module pp_dma_chan_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              per_req,
    input logic              per_ack,
    input logic              en,
    input logic [1:0]        state,
    input logic [1:0]        slot_valid,
    input logic [31:0]       reg_rdata,
    input logic [7:0]        reg_addr,
    input logic              irq
);
    // R3
    req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (per_req && en));
    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> $stable(mem_addr));
    // R4
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |-> (mem_req && mem_ready));
    // R6
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd1) |-> !mem_req);
    // R2
    next_both_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd3) |-> (slot_valid == 2'b11));
    // R10
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == 2'd0));
    // R9
    irq_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 8'h00 && (reg_rdata & 32'h0B) == 32'd0) |-> !irq);
endmodule

bind pingpong_dma_chan pp_dma_chan_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .per_req(per_req), .per_ack(per_ack), .en(en),
    .state(state), .slot_valid(slot_valid), .reg_rdata(reg_rdata),
    .reg_addr(reg_addr), .irq(irq)
);

// File: tb/pingpong_dma_chan_tb.sv
// Directed bench for the ping-pong DMA channel: one task per scenario.
module pingpong_dma_chan_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, per_ack, irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, per_wdata;
    logic        mem_ready = 1'b1;
    logic        mem_err = 1'b0;
    logic        per_req = 1'b0;
    logic [3:0]  per_sel;
    logic [31:0] per_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;
    assign mem_rdata = mem_addr ^ 32'h5A5A_0000;

    pingpong_dma_chan u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .per_req(per_req), .per_ack(per_ack), .per_sel(per_sel),
        .per_wdata(per_wdata), .per_rdata(per_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 8'h00;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = 8'h00;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h0C, v); chk("R1 status", v, 0);
        rd(8'h00, v); chk("R1 control", v, 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 mem_req", 32'(mem_req), 0);
    endtask

    task automatic t_port();
        logic [31:0] v;
        wr(8'h08, 32'hFFFF_FFF5);
        rd(8'h08, v); chk("R11 port readback", v, 32'h5);
        chk("R11 per_sel", 32'(per_sel), 32'h5);
    endtask

    task automatic t_pingpong();
        logic [31:0] v;
        logic [31:0] exp_a [5] = '{32'h1000, 32'h1004, 32'h1008, 32'h2000, 32'h2004};
        wr(8'h00, 32'h13);
        wr(8'h24, 32'h1000); wr(8'h20, 12);
        rd(8'h0C, v); chk("R2 one slot on", v, 32'h20);
        wr(8'h34, 32'h2000); wr(8'h30, 6);
        rd(8'h0C, v); chk("R2 both slots next", v, 32'h30);
        per_req = 1'b1;
        for (int i = 0; i < 5; i++) begin
            #1;
            chk("R3 mem_req", 32'(mem_req), 1);
            chk("R3 address", mem_addr, exp_a[i]);
            if (i == 0) begin
                chk("R4 read dir", 32'(mem_we), 0);
                chk("R4 per_wdata", per_wdata, 32'h1000 ^ 32'h5A5A_0000);
            end
            if (i == 3) begin
                rd(8'h0C, v); chk("R5 on after switch", v, 32'h20);
                rd(8'h04, v); chk("R5 free flag", v, 32'h2);
            end
            @(negedge clk);
        end
        #1;
        rd(8'h0C, v); chk("R6 stall status", v, 32'h10);
        rd(8'h04, v); chk("R6 stall+free flags", v, 32'h3);
        chk("R6 mem_req low", 32'(mem_req), 0);
        chk("R9 irq", 32'(irq), 1);
        rd(8'h30, v); chk("R12 partial word drains", v, 0);
    endtask

    task automatic t_refill();
        logic [31:0] v;
        rd(8'h24, v); chk("R3 base readback", v, 32'h100C);
        wr(8'h24, 32'h3000); wr(8'h20, 4);
        #1;
        rd(8'h04, v); chk("R7 free flag cleared", v, 0);
        rd(8'h0C, v); chk("R6 resume on", v, 32'h20);
        chk("R6 resume addr", mem_addr, 32'h3000);
        @(negedge clk); #1;
        rd(8'h0C, v); chk("R6 stall again", v, 32'h10);
    endtask

    task automatic t_to_mem();
        per_req = 1'b0;
        per_rdata = 32'hCAFE_F00D;
        wr(8'h00, 32'h17);
        wr(8'h34, 32'h4000); wr(8'h30, 8);
        per_req = 1'b1;
        #1;
        chk("R4 write dir", 32'(mem_we), 1);
        chk("R4 mem_wdata", mem_wdata, 32'hCAFE_F00D);
        chk("R4 per_ack", 32'(per_ack), 1);
        chk("R3 addr to_mem", mem_addr, 32'h4000);
        repeat (2) @(negedge clk);
        per_req = 1'b0;
    endtask

    task automatic t_error();
        logic [31:0] v;
        wr(8'h00, 32'h18);
        #1; chk("R9 irq masked", 32'(irq), 0);
        wr(8'h24, 32'h5000); wr(8'h20, 4);
        mem_err = 1'b1; per_req = 1'b1;
        @(negedge clk);
        mem_err = 1'b0; per_req = 1'b0;
        #1;
        rd(8'h04, v); chk("R8 error flag", v & 32'h8, 32'h8);
        chk("R9 irq on error", 32'(irq), 1);
        wr(8'h04, 32'h8);
        #1;
        rd(8'h04, v); chk("R8 error cleared", v & 32'h8, 0);
        chk("R9 irq after clear", 32'(irq), 0);
        wr(8'h00, 32'h58);
        wr(8'h34, 32'h5100); wr(8'h30, 4);
        mem_err = 1'b1; per_req = 1'b1;
        @(negedge clk);
        mem_err = 1'b0; per_req = 1'b0;
        #1;
        rd(8'h04, v); chk("R8 error ignored", v & 32'h8, 0);
        chk("R8 irq ignored", 32'(irq), 0);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        int n;
        wr(8'h00, 32'h13);
        wr(8'h24, 32'h6000); wr(8'h20, 64);
        per_req = 1'b1;
        repeat (2) @(negedge clk);
        wr(8'h00, 32'h0);
        #1; chk("R10 mem_req drops", 32'(mem_req), 0);
        @(negedge clk); #1;
        rd(8'h0C, v); chk("R10 idle", v, 0);
        per_req = 1'b0;
        wr(8'h20, 0); wr(8'h30, 0);
        wr(8'h00, 32'h13);
        rd(8'h0C, v); chk("R2 zero count empty", v, 0);
        wr(8'h24, 32'h7000); wr(8'h20, 8);
        per_req = 1'b1;
        wr(8'h00, 32'h10);
        n = 0;
        rd(8'h0C, v);
        while (v[5:4] >= 2 && n < 20) begin @(negedge clk); rd(8'h0C, v); n++; end
        wr(8'h00, 32'h0);
        n = 0;
        rd(8'h0C, v);
        while (v[5:4] == 1 && n < 20) begin @(negedge clk); rd(8'h0C, v); n++; end
        chk("R10 shutdown idle", v, 0);
        chk("R10 shutdown irq", 32'(irq), 0);
        per_req = 1'b0;
    endtask

    task automatic t_count_mask();
        logic [31:0] v;
        wr(8'h00, 32'h10);
        wr(8'h24, 32'h8000); wr(8'h20, 32'h0001_0005);
        rd(8'h20, v); chk("R12 count masked", v, 32'h5);
        per_req = 1'b1;
        #1; chk("R12 first addr", mem_addr, 32'h8000);
        @(negedge clk); #1; chk("R12 second addr", mem_addr, 32'h8004);
        @(negedge clk);
        per_req = 1'b0;
        #1;
        rd(8'h20, v); chk("R12 count zero", v, 0);
        rd(8'h0C, v); chk("R12 stall after remainder", v, 32'h10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset();
        t_port();
        t_pingpong();
        t_refill();
        t_to_mem();
        t_error();
        t_disable();
        t_count_mask();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule